// File: doc/BRIEF.md
# Sequential Floating-Point Multiplier

This unit forms the product of two floating-point operands over several clock cycles. Each operand has three parts: a sign bit, a normalized fractional mantissa whose top bit is 1 (a value in [0.5, 1)), and an exponent held with a fixed bias. A one-cycle start strobe latches both operands. A one-cycle done pulse then marks that the product's sign, mantissa and exponent are valid.

A zero mantissa on either side ends the operation at once with an all-zero result. For any other pair, the unit first forms the exponent sum. It removes one copy of the bias from that sum, so the result is biased exactly once. It then multiplies the mantissas one multiplier bit per cycle into a double-length product. The last step corrects the leading bit with at most one left shift, which also lowers the exponent by one. The unit keeps the upper half of the product and drops the lower half, so the mantissa is truncated and never rounded. Exponent arithmetic wraps modulo 2^EXP_W. Special values and range traps are not handled.

Top module: `fpm_seq_top`

## Requirements
- R1: While reset is held and after it is released, done_o is 0 and p_sign_o, p_man_o and p_exp_o are all 0.
- R2: A start with either mantissa equal to 0 gives p_sign_o=0, p_man_o=0 and p_exp_o=0, with done_o high in the single cycle after the start edge.
- R3: For nonzero operands, p_sign_o is the XOR of a_sign_i and b_sign_i.
- R4: When the product's top bit (bit 2*MAN_W-1) is 1, p_exp_o equals (a_exp_i + b_exp_i - BIAS) mod 2^EXP_W.
- R5: p_man_o is the upper MAN_W bits of the normalized 2*MAN_W-bit product of the fraction mantissas. The lower half is discarded without rounding.
- R6: When the product's top bit is 0, the double-length product is shifted left once and p_exp_o is (a_exp_i + b_exp_i - BIAS - 1) mod 2^EXP_W. Normalized inputs never need a second shift.
- R7: For nonzero operands, done_o rises MAN_W+1 cycles after the clock edge that samples start_i.
- R8: done_o is high for exactly one cycle per accepted operation.
- R9: start_i is ignored while an operation is in progress. It neither alters the result nor produces an extra done pulse.
- R10: The product outputs change only in cycles where done_o is high, and otherwise hold their last value.
- R11: A start presented in the cycle where done_o is high is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| a_sign_i | input | 1 | Multiplicand sign |
| a_man_i | input | MAN_W | Multiplicand fraction mantissa |
| a_exp_i | input | EXP_W | Multiplicand biased exponent |
| b_sign_i | input | 1 | Multiplier sign |
| b_man_i | input | MAN_W | Multiplier fraction mantissa |
| b_exp_i | input | EXP_W | Multiplier biased exponent |
| p_sign_o | output | 1 | Product sign |
| p_man_o | output | MAN_W | Product mantissa, upper half |
| p_exp_o | output | EXP_W | Product biased exponent |
| done_o | output | 1 | One-cycle result strobe |

## Verification
Two events can fall in the same cycle: the done pulse of one operation and the acceptance of the next start.

The bench provokes this on every operation of its sweep. Each new start is driven in the very cycle whose done pulse it has just checked. The bench then judges the outcome in three ways:
- done_o must drop on the following edge.
- The old result must stay unchanged through the whole multiply.
- The new result must arrive exactly MAN_W+1 cycles later.

A second case drives a start strobe one cycle into a running multiply. The bench requires the first product to appear unchanged, with no second done pulse.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_NORM = 2'd2
  } fpm_state_e;
endpackage

// File: rtl/fpm_exp_unit.sv
module fpm_exp_unit #(
  parameter int EXP_W = 6,
  parameter int BIAS  = 32
) (
  input  logic [EXP_W-1:0] a_exp_i,
  input  logic [EXP_W-1:0] b_exp_i,
  output logic [EXP_W-1:0] sum_o
);
  localparam int SW = EXP_W + 2;
  localparam logic [SW-1:0] BIAS_V = SW'(BIAS);

  logic [SW-1:0] raw;
  // double bias from the add, one removed
  assign raw   = {2'b00, a_exp_i} + {2'b00, b_exp_i} - BIAS_V;
  assign sum_o = raw[EXP_W-1:0];
endmodule

// File: rtl/fpm_mant_mul.sv
module fpm_mant_mul #(
  parameter int MAN_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [MAN_W-1:0]   mcand_i,
  input  logic [MAN_W-1:0]   mplier_i,
  output logic               last_o,
  output logic [2*MAN_W-1:0] prod_o
);
  localparam int CNT_W = $clog2(MAN_W + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(MAN_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [MAN_W-1:0] acc_q, q_q, b_q;
  logic [CNT_W-1:0] cnt_q;
  logic [MAN_W:0]   sum;

  assign sum    = {1'b0, acc_q} + (q_q[0] ? {1'b0, b_q} : '0);
  assign last_o = (cnt_q == CNT_ONE);
  assign prod_o = {acc_q, q_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      q_q   <= '0;
      b_q   <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      acc_q <= '0;
      q_q   <= mplier_i;
      b_q   <= mcand_i;
      cnt_q <= CNT_INIT;
    end else if (cnt_q != '0) begin
      acc_q <= sum[MAN_W:1];
      q_q   <= {sum[0], q_q[MAN_W-1:1]};
      cnt_q <= cnt_q - CNT_ONE;
    end
  end

  // R7
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_INIT);
endmodule

// File: rtl/fpm_seq_top.sv
module fpm_seq_top
  import fpm_pkg::*;
#(
  parameter int MAN_W = 8,
  parameter int EXP_W = 6,
  parameter int BIAS  = 2 ** (EXP_W - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             a_sign_i,
  input  logic [MAN_W-1:0] a_man_i,
  input  logic [EXP_W-1:0] a_exp_i,
  input  logic             b_sign_i,
  input  logic [MAN_W-1:0] b_man_i,
  input  logic [EXP_W-1:0] b_exp_i,
  output logic             p_sign_o,
  output logic [MAN_W-1:0] p_man_o,
  output logic [EXP_W-1:0] p_exp_o,
  output logic             done_o
);
  localparam int PROD_W = 2 * MAN_W;
  localparam logic [EXP_W-1:0] EXP_ONE = EXP_W'(1);

  fpm_state_e        state_q;
  logic              sign_q, norm_in_q;
  logic [EXP_W-1:0]  exp_q, exp_sum;
  logic              zero_in, accept, mul_load, mul_last;
  logic [PROD_W-1:0] prod;
  logic              p_sign_q, done_q;
  logic [MAN_W-1:0]  p_man_q;
  logic [EXP_W-1:0]  p_exp_q;

  assign zero_in  = (a_man_i == '0) || (b_man_i == '0);
  assign accept   = (state_q == ST_IDLE) && start_i;
  assign mul_load = accept && !zero_in;

  fpm_exp_unit #(.EXP_W(EXP_W), .BIAS(BIAS)) i_exp (
    .a_exp_i (a_exp_i),
    .b_exp_i (b_exp_i),
    .sum_o   (exp_sum)
  );

  fpm_mant_mul #(.MAN_W(MAN_W)) i_mul (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (mul_load),
    .mcand_i  (a_man_i),
    .mplier_i (b_man_i),
    .last_o   (mul_last),
    .prod_o   (prod)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sign_q    <= 1'b0;
      exp_q     <= '0;
      norm_in_q <= 1'b0;
      p_sign_q  <= 1'b0;
      p_man_q   <= '0;
      p_exp_q   <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (zero_in) begin
            p_sign_q <= 1'b0;
            p_man_q  <= '0;
            p_exp_q  <= '0;
            done_q   <= 1'b1;
          end else begin
            sign_q    <= a_sign_i ^ b_sign_i;
            exp_q     <= exp_sum;
            norm_in_q <= a_man_i[MAN_W-1] & b_man_i[MAN_W-1];
            state_q   <= ST_MUL;
          end
        end
        ST_MUL: if (mul_last) state_q <= ST_NORM;
        ST_NORM: begin
          p_sign_q <= sign_q;
          if (prod[PROD_W-1]) begin
            p_man_q <= prod[PROD_W-1:MAN_W];
            p_exp_q <= exp_q;
          end else begin
            p_man_q <= prod[PROD_W-2:MAN_W-1];
            p_exp_q <= exp_q - EXP_ONE;
          end
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign p_sign_o = p_sign_q;
  assign p_man_o  = p_man_q;
  assign p_exp_o  = p_exp_q;
  assign done_o   = done_q;

  // R2
  zero_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && zero_in |=> done_o && !p_sign_o && p_man_o == '0 && p_exp_o == '0);
  // R6
  norm_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_NORM && norm_in_q |-> prod[PROD_W-1] || prod[PROD_W-2]);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o || $past(accept && zero_in));
  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(p_man_o) && $stable(p_exp_o) && $stable(p_sign_o));
  // R9
  start_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && state_q != ST_IDLE |=> $stable(exp_q) && $stable(sign_q));
endmodule

// File: tb/test_fpm_seq_top.sv
module test_fpm_seq_top;
  localparam int MW = 4;
  localparam int EW = 5;
  localparam int BS = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          a_sign_i = 1'b0, b_sign_i = 1'b0;
  logic [MW-1:0] a_man_i = '0, b_man_i = '0;
  logic [EW-1:0] a_exp_i = '0, b_exp_i = '0;
  logic          p_sign_o, done_o;
  logic [MW-1:0] p_man_o;
  logic [EW-1:0] p_exp_o;

  int n_chk = 0;
  int n_bad = 0;
  int prev_s = 0, prev_m = 0, prev_e = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  fpm_seq_top #(.MAN_W(MW), .EXP_W(EW), .BIAS(BS)) i_fpm_seq_top (
    .clk_i, .rst_ni, .start_i,
    .a_sign_i, .a_man_i, .a_exp_i,
    .b_sign_i, .b_man_i, .b_exp_i,
    .p_sign_o, .p_man_o, .p_exp_o, .done_o
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_hold(input string tag);
    check(int'(p_man_o) == prev_m && int'(p_exp_o) == prev_e && int'(p_sign_o) == prev_s,
          tag, int'(p_man_o), prev_m);
  endtask

  // called at a negedge; leaves at the negedge of the done cycle
  task automatic run_op(input int sa, input int ma, input int ea,
                        input int sb, input int mb, input int eb, input bit intrude);
    int prod, sh, em, es, ee;
    bit b2b;
    b2b  = done_o;
    prod = ma * mb;
    sh   = (prod < (1 << (2*MW-1))) ? 1 : 0;
    if (sh == 1) prod = prod << 1;
    em = (prod >> MW) & ((1 << MW) - 1);
    ee = (ea + eb - BS - sh) & ((1 << EW) - 1);
    es = sa ^ sb;
    a_sign_i = sa[0]; a_man_i = MW'(ma); a_exp_i = EW'(ea);
    b_sign_i = sb[0]; b_man_i = MW'(mb); b_exp_i = EW'(eb);
    start_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
    if (ma == 0 || mb == 0) begin
      // R2
      check(done_o && p_man_o == '0 && p_exp_o == '0 && !p_sign_o, "R2",
            int'(p_man_o) + int'(p_exp_o), 0);
      prev_s = 0; prev_m = 0; prev_e = 0;
      return;
    end
    for (int i = 1; i <= MW; i++) begin
      if (intrude && i == 1) begin
        a_man_i = MW'(15 - ma + 8); b_man_i = MW'(9); a_exp_i = EW'(ea + 3);
        a_sign_i = ~sa[0];
        start_i = 1'b1;
      end
      @(posedge clk_i); @(negedge clk_i);
      start_i = 1'b0;
      check(!done_o, (i == 1) ? "R8" : (intrude ? "R9" : "R7"), int'(done_o), 0);
      check_hold("R10");
    end
    @(posedge clk_i); @(negedge clk_i);
    check(done_o, "R7", int'(done_o), 1);
    if (b2b) check(done_o, "R11", int'(done_o), 1);
    check(int'(p_sign_o) == es, "R3", int'(p_sign_o), es);
    check(int'(p_man_o) == em, intrude ? "R9" : "R5", int'(p_man_o), em);
    check(int'(p_exp_o) == ee, (sh == 1) ? "R6" : "R4", int'(p_exp_o), ee);
    prev_s = es; prev_m = em; prev_e = ee;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    check(!done_o && p_man_o == '0 && p_exp_o == '0 && !p_sign_o, "R1", int'(p_man_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!done_o && p_man_o == '0 && p_exp_o == '0 && !p_sign_o, "R1", int'(done_o), 0);

    // sweep: zero and all normalized mantissas, back-to-back starts (R11)
    for (int i = 0; i < 9; i++) begin
      for (int j = 0; j < 9; j++) begin
        run_op(i & 1, (i == 0) ? 0 : 7 + i, (i * 7 + j * 3 + 3) % 32,
               (j >> 1) & 1, (j == 0) ? 0 : 7 + j, (j * 5 + 11) % 32, 1'b0);
      end
    end

    // exponent wrap with a normalizing shift
    run_op(0, 8, 0, 1, 8, 0, 1'b0);
    // largest product, no shift
    run_op(1, 15, 31, 1, 15, 31, 1'b0);

    // start while busy (R9)
    @(negedge clk_i);
    run_op(0, 12, 20, 1, 10, 9, 1'b1);
    for (int k = 0; k < MW + 3; k++) begin
      @(posedge clk_i); @(negedge clk_i);
      check(!done_o, "R9", int'(done_o), 0);
      check_hold("R10");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule